// File: doc/BRIEF.md
# CAM Instruction Register Sequencer

This block is the control front end of a content-addressable memory, used when operations arrive as instruction words on the data bus instead of on dedicated control lines. A write cycle with the address-valid strobe high loads a 12-bit instruction from the low data bits into an instruction register. An extra data bit selects the read or write flavour of that control state.

Instructions that move no data fire in the same cycle as their load. Data-moving instructions are kept pending. They then fire on every later data cycle (address-valid low) until another instruction replaces them. A read cycle with the address-valid strobe high selects the status register. When the mode bits are not both set, the block passes the dedicated control lines through unchanged.

The memory array lies outside this block. The block shows what the array must do through an operation strobe, an operation code, a direction flag and a data-use flag. During deferred execution it also passes on the validity of the addressed location.

Top module: `cam_instr_seq`

## Requirements
- R1: Instruction mode is active only when `cfg_mode` is 2'b11. In any other mode, a valid cycle with a nonzero `ctl_code` drives `op_fire`=1, `op_code`=`ctl_code` and `op_rd`=!`cyc_write`. In that mode, cycles with `av_hi` high do not load the instruction register.
- R2: In instruction mode, a valid write cycle with `av_hi`=1 loads `dq[11:0]` as the instruction and `dq[12]` as its flavour, where 1 means read form and 0 means write form.
- R3: A loaded instruction whose bits [11:8] are not in the range 1 to 5 is immediate. It fires in its load cycle with `op_code`=`dq[11:0]`, `op_rd`=`dq[12]` and `op_data`=0. The all-zero code is a no-operation and never fires.
- R4: A loaded instruction whose bits [11:8] are 1 to 5 is deferred and does not fire on load. The next valid cycle with `av_hi`=0 fires it with the stored code, the stored flavour and `op_data`=1.
- R5: A deferred instruction fires again on every later data cycle until a new instruction is loaded. Idle cycles fire nothing.
- R6: While the register holds an immediate instruction or the no-operation code, data cycles fire nothing.
- R7: In instruction mode, a valid read cycle with `av_hi`=1 asserts `stat_rd_sel` and fires no operation. In the other modes `stat_rd_sel` stays 0.
- R8: `vb_out` equals `loc_valid` during any firing with `op_data`=1, and is 0 otherwise.
- R9: After reset the register holds the no-operation code and `ir_deferred`=0, so data cycles fire nothing.
- R10: `ir_deferred` is registered. From the cycle after a load it shows whether the loaded code is deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Mode bits; 2'b11 selects instruction mode |
| cyc_valid | input | 1 | A bus cycle occurs this clock |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| av_hi | input | 1 | Address-valid strobe level (1 = control/status side) |
| dq | input | 32 | Data bus |
| ctl_code | input | 12 | Dedicated control lines (line mode) |
| loc_valid | input | 1 | Validity of the addressed location from the array |
| op_fire | output | 1 | Operation strobe |
| op_code | output | 12 | Operation being executed |
| op_rd | output | 1 | 1 = read form of the operation |
| op_data | output | 1 | Operation transfers data on the bus |
| stat_rd_sel | output | 1 | Status register read select |
| vb_out | output | 1 | Validity of the accessed location |
| ir_deferred | output | 1 | Registered class flag of the held instruction |

## Verification
The hardest state to reach is a deferred instruction that repeats across data cycles of both directions with idle cycles in between, and is then replaced. The bench loads a memory-class code and runs a write data cycle, a read data cycle, an idle cycle and another data cycle. It then loads an immediate code and shows that data cycles go silent. Separately, the bench sends a load-shaped write in line mode and afterwards shows in instruction mode that the register was not touched.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;
   parameter int unsigned CAM_OPC_W  = 12;
   parameter int unsigned CAM_DATA_W = 32;

   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,
      CYC_LOAD = 2'd1,
      CYC_STAT = 2'd2,
      CYC_DATA = 2'd3
   } cyc_kind_e;

   function automatic cyc_kind_e cyc_kind(input logic valid, input logic wr, input logic av);
      if (!valid)  return CYC_IDLE;
      if (!av)     return CYC_DATA;
      if (wr)      return CYC_LOAD;
      return CYC_STAT;
   endfunction
endpackage

// File: rtl/cam_op_classify.sv
module cam_op_classify #(
   parameter int unsigned OPC_W      = 12,
   parameter int unsigned CLS_W      = 4,
   parameter logic [15:0] DEFER_MASK = 16'h003E
) (
   input  logic [OPC_W-1:0] code,
   output logic             deferred
);
   localparam int unsigned N_CLS = 1 << CLS_W;

   generate
      if (CLS_W > OPC_W || CLS_W > 4) begin : g_bad_cls
         $error("cam_op_classify: class field wider than opcode or mask");
      end
   endgenerate

   logic [N_CLS-1:0] lut;
   generate
      for (genvar g = 0; g < N_CLS; g++) begin : g_lut
         assign lut[g] = DEFER_MASK[g];
      end
   endgenerate

   assign deferred = lut[code[OPC_W-1 -: CLS_W]];
endmodule

// File: rtl/cam_ir_reg.sv
module cam_ir_reg #(
   parameter int unsigned OPC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OPC_W-1:0] code_in,
   input  logic             rd_in,
   input  logic             defer_in,
   output logic [OPC_W-1:0] ir_code,
   output logic             ir_rd,
   output logic             ir_defer
);
   localparam logic [OPC_W-1:0] NOP = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_code  <= NOP;
         ir_rd    <= 1'b0;
         ir_defer <= 1'b0;
      end else if (load) begin
         ir_code  <= code_in;
         ir_rd    <= rd_in;
         ir_defer <= defer_in;
      end
   end

   AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ir_code == $past(code_in) && ir_rd == $past(rd_in))); // R2
   AST_IR_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(ir_code) && $stable(ir_defer))); // R5
   AST_CLASS_REG: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (ir_defer == $past(defer_in))); // R10
endmodule

// File: rtl/cam_instr_seq.sv
module cam_instr_seq
   import cam_seq_pkg::*;
#(
   parameter int unsigned OPC_W      = CAM_OPC_W,
   parameter int unsigned DATA_W     = CAM_DATA_W,
   parameter int unsigned CLS_W      = 4,
   parameter logic [15:0] DEFER_MASK = 16'h003E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic              cyc_valid,
   input  logic              cyc_write,
   input  logic              av_hi,
   input  logic [DATA_W-1:0] dq,
   input  logic [OPC_W-1:0]  ctl_code,
   input  logic              loc_valid,
   output logic              op_fire,
   output logic [OPC_W-1:0]  op_code,
   output logic              op_rd,
   output logic              op_data,
   output logic              stat_rd_sel,
   output logic              vb_out,
   output logic              ir_deferred
);
   localparam int unsigned SEL_BIT = OPC_W;
   localparam logic [OPC_W-1:0] NOP = '0;

   generate
      if (DATA_W <= SEL_BIT) begin : g_bad_width
         $error("cam_instr_seq: data bus must carry opcode plus flavour bit");
      end
   endgenerate

   logic      ir_mode;
   cyc_kind_e kind;
   logic      load;
   logic [OPC_W-1:0] bus_code;
   logic      bus_rd, bus_defer, ctl_defer;
   logic [OPC_W-1:0] ir_code;
   logic      ir_rd, ir_defer;

   assign ir_mode  = &cfg_mode;
   assign kind     = cyc_kind(cyc_valid, cyc_write, av_hi);
   assign load     = ir_mode && (kind == CYC_LOAD);
   assign bus_code = dq[OPC_W-1:0];
   assign bus_rd   = dq[SEL_BIT];

   cam_op_classify #(.OPC_W(OPC_W), .CLS_W(CLS_W), .DEFER_MASK(DEFER_MASK)) u_cls_bus (
      .code(bus_code), .deferred(bus_defer));
   cam_op_classify #(.OPC_W(OPC_W), .CLS_W(CLS_W), .DEFER_MASK(DEFER_MASK)) u_cls_ctl (
      .code(ctl_code), .deferred(ctl_defer));

   cam_ir_reg #(.OPC_W(OPC_W)) u_ir (
      .clk(clk), .rst_n(rst_n), .load(load), .code_in(bus_code), .rd_in(bus_rd),
      .defer_in(bus_defer), .ir_code(ir_code), .ir_rd(ir_rd), .ir_defer(ir_defer));

   assign ir_deferred = ir_defer;

   always_comb begin
      op_fire     = 1'b0;
      op_code     = NOP;
      op_rd       = 1'b0;
      op_data     = 1'b0;
      stat_rd_sel = 1'b0;
      if (!ir_mode) begin
         if (cyc_valid && ctl_code != NOP) begin
            op_fire = 1'b1;
            op_code = ctl_code;
            op_rd   = !cyc_write;
            op_data = ctl_defer;
         end
      end else begin
         unique case (kind)
            CYC_LOAD: if (!bus_defer && bus_code != NOP) begin
               op_fire = 1'b1;
               op_code = bus_code;
               op_rd   = bus_rd;
            end
            CYC_DATA: if (ir_defer && ir_code != NOP) begin
               op_fire = 1'b1;
               op_code = ir_code;
               op_rd   = ir_rd;
               op_data = 1'b1;
            end
            CYC_STAT: stat_rd_sel = 1'b1;
            default: ;
         endcase
      end
   end

   assign vb_out = op_fire && op_data && loc_valid;

   AST_LINE_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_mode |-> !stat_rd_sel); // R7
   AST_STAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_fire, stat_rd_sel})); // R7
   AST_DEFER_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_mode && ir_deferred && cyc_valid && !av_hi) |-> (op_fire && op_data)); // R5
   AST_NO_FIRE_ON_DEFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_mode && cyc_valid && cyc_write && av_hi && op_fire) |-> !op_data); // R4
   AST_VB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      vb_out |-> (op_fire && op_data && loc_valid)); // R8
   AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      op_fire |-> (op_code != NOP)); // R3
endmodule

// File: tb/cam_instr_seq_bench.sv
module cam_instr_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_mode = 2'b11;
   logic        cyc_valid = 1'b0, cyc_write = 1'b0, av_hi = 1'b0, loc_valid = 1'b0;
   logic [31:0] dq = '0;
   logic [11:0] ctl_code = '0;
   logic        op_fire, op_rd, op_data, stat_rd_sel, vb_out, ir_deferred;
   logic [11:0] op_code;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cam_instr_seq u_cam_instr_seq (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cyc_valid(cyc_valid),
      .cyc_write(cyc_write), .av_hi(av_hi), .dq(dq), .ctl_code(ctl_code),
      .loc_valid(loc_valid), .op_fire(op_fire), .op_code(op_code), .op_rd(op_rd),
      .op_data(op_data), .stat_rd_sel(stat_rd_sel), .vb_out(vb_out),
      .ir_deferred(ir_deferred));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // drive at negedge, settle 1 ns before sampling
   task automatic cyc(input logic v, input logic w, input logic av,
                      input logic [31:0] d, input logic lv);
      @(negedge clk);
      cyc_valid = v; cyc_write = w; av_hi = av; dq = d; loc_valid = lv;
      #1;
   endtask

   task automatic t_reset;
      cyc(1, 1, 0, 32'h0000_5123, 1);
      chk("R9 fire after reset", op_fire, 0);
      chk("R9 class flag", ir_deferred, 0);
      chk("R8 vb idle", vb_out, 0);
   endtask

   task automatic t_immediate;
      cyc(1, 1, 1, 32'h0000_17A5, 0);
      chk("R3 fire", op_fire, 1);
      chk("R3 code", op_code, 12'h7A5);
      chk("R2 flavour read", op_rd, 1);
      chk("R3 data flag", op_data, 0);
      cyc(1, 0, 0, 32'h0, 1);
      chk("R10 class immediate", ir_deferred, 0);
      chk("R6 data cycle silent", op_fire, 0);
      cyc(1, 1, 1, 32'h0000_1000, 0);
      chk("R3 nop silent", op_fire, 0);
      cyc(1, 1, 1, 32'h0000_0600, 0);
      chk("R3 class 6 immediate", op_fire, 1);
      chk("R3 class 6 data", op_data, 0);
   endtask

   task automatic t_deferred;
      cyc(1, 1, 1, 32'h0000_0130, 1);
      chk("R4 no fire on load", op_fire, 0);
      cyc(1, 1, 0, 32'hDEAD_BEEF, 1);
      chk("R10 class deferred", ir_deferred, 1);
      chk("R4 fire", op_fire, 1);
      chk("R4 code", op_code, 12'h130);
      chk("R2 flavour write", op_rd, 0);
      chk("R4 data flag", op_data, 1);
      chk("R8 vb valid", vb_out, 1);
      cyc(1, 0, 0, 32'h0, 0);
      chk("R5 repeat read", op_fire, 1);
      chk("R8 vb invalid", vb_out, 0);
      cyc(0, 0, 0, 32'h0, 1);
      chk("R5 idle silent", op_fire, 0);
      cyc(1, 0, 0, 32'h0, 1);
      chk("R5 repeat after idle", op_code, 12'h130);
      cyc(1, 1, 1, 32'h0000_15FF, 0);
      chk("R4 set-full class no fire", op_fire, 0);
      cyc(1, 0, 0, 32'h0, 0);
      chk("R4 class 5 fires", op_code, 12'h5FF);
      chk("R4 class 5 read form", op_rd, 1);
      cyc(1, 1, 1, 32'h0000_0812, 0);
      chk("R3 replace fires", op_code, 12'h812);
      cyc(1, 1, 0, 32'h0, 1);
      chk("R5 replaced silent", op_fire, 0);
   endtask

   task automatic t_status;
      cyc(1, 0, 1, 32'h0, 0);
      chk("R7 status sel", stat_rd_sel, 1);
      chk("R7 no fire", op_fire, 0);
   endtask

   task automatic t_line;
      cfg_mode = 2'b10; ctl_code = 12'h055;
      cyc(1, 1, 1, 32'h0000_0130, 0);
      chk("R1 line fire", op_fire, 1);
      chk("R1 line code", op_code, 12'h055);
      chk("R1 line dir", op_rd, 0);
      cyc(1, 0, 1, 32'h0, 0);
      chk("R7 line no status", stat_rd_sel, 0);
      chk("R1 line read dir", op_rd, 1);
      ctl_code = 12'h000;
      cyc(1, 0, 0, 32'h0, 0);
      chk("R1 line nop", op_fire, 0);
      cfg_mode = 2'b11;
      cyc(1, 1, 0, 32'h0, 1);
      chk("R1 no load in line mode", op_fire, 0);
      chk("R1 class kept", ir_deferred, 0);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_immediate();
      t_deferred();
      t_status();
      t_line();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule